// File: doc/BRIEF.md
# Checked Double-Width Integer Divider

This block divides a dividend of twice the operand width by a divisor of operand width. It returns a quotient and a remainder, each of operand width, or it raises a divide-error flag when no representable result exists. A single input selects unsigned or two's-complement signed arithmetic. The operand width `W` is a parameter and may be 8, 16, 32 or 64.

The work is done by a restoring shift-subtract loop that retires one quotient bit per clock. In signed mode the block divides magnitudes and corrects the signs at the end. Two kinds of error are caught before the loop starts and cost one cycle: a zero divisor, and an upper dividend half that is not smaller than the divisor magnitude. The signed quotient range is asymmetric, so the remaining cases are caught after the loop.

The handshake is simple. A caller pulses `start_i` while `busy_o` is low. It then waits for the one-cycle `done_o` pulse and reads `div_err_o` together with the results.

Top module: `dbl_div`

## Requirements
- R1: A zero divisor makes `done_o` pulse with `div_err_o` high in the cycle after the accepted start, in either mode, and `busy_o` never rises.
- R2: In unsigned mode, when the upper `W` bits of the dividend are greater than or equal to the divisor (the quotient exceeds 2^W-1), the operation ends with `div_err_o` high one cycle after start.
- R3: In signed mode, a quotient above 2^(W-1)-1 is a divide error. This covers the case where operands of equal sign give a magnitude of 2^(W-1).
- R4: In signed mode with operands of opposite sign, a quotient of exactly -2^(W-1) is legal and is returned without error.
- R5: In unsigned mode without error, `quot_o` is floor(dividend/divisor) and `rem_o` is dividend mod divisor. This includes the largest quotient 2^W-1 and divisors with the top bit set.
- R6: In signed mode without error, the quotient is truncated toward zero and the remainder is zero or has the sign of the dividend.
- R7: On a divide error, `quot_o` and `rem_o` keep the values from the last successful operation.
- R8: `done_o` is high for exactly one cycle per accepted operation, and `div_err_o` is valid while it is high.
- R9: `start_i` is ignored while `busy_o` is high: the running operation completes with its own operands, and no further `done_o` pulse follows.
- R10: A non-error operation keeps `busy_o` high for exactly W+1 cycles: W iteration cycles and one sign-correction cycle. `done_o` rises in the cycle in which `busy_o` falls.
- R11: `packed_o` equals {`rem_o`, `quot_o`}, with the remainder in the upper W bits and the quotient in the lower W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when not busy |
| signed_i | input | 1 | 1 selects two's-complement signed division |
| dividend_i | input | 2*W | Double-width dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error for the last completed operation |
| quot_o | output | W | Quotient |
| rem_o | output | W | Remainder |
| packed_o | output | 2*W | Remainder in the upper half, quotient in the lower half |

## Verification
The hardest case to reach is a signed overflow that passes the early upper-half test and is caught only after the full loop. Such a quotient magnitude is exactly 2^(W-1) with operands of equal sign. The stimulus drives 32768/1 and 32768/-1 at W=16, so that the same magnitude gives an error in one sign case and a legal -32768 in the other. The iteration where a bit shifts out of the high half is forced with a divisor of 0x8001 and an upper half of 0x8000. A second start is injected in the middle of a run to show that it is dropped.

// File: rtl/dbl_div_pkg.sv
package dbl_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dd_state_e;
endpackage

// File: rtl/dbl_div_prep.sv
// Sign stripping and early error detection
module dbl_div_prep #(
  parameter int W = 16
) (
  input  logic           signed_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   dmag_o,
  output logic           neg_q_o,
  output logic           neg_r_o,
  output logic           early_err_o
);
  localparam int DW = 2 * W;

  logic          sa, sb;
  logic [DW-1:0] nmag;

  always_comb begin
    sa          = signed_i & dividend_i[DW-1];
    sb          = signed_i & divisor_i[W-1];
    nmag        = sa ? (~dividend_i + DW'(1)) : dividend_i;
    dmag_o      = sb ? (~divisor_i + W'(1)) : divisor_i;
    hi_o        = nmag[DW-1:W];
    lo_o        = nmag[W-1:0];
    neg_q_o     = sa ^ sb;
    neg_r_o     = sa;
    // zero divisor is covered: any upper half is >= 0
    early_err_o = (divisor_i == '0) | (hi_o >= dmag_o);
  end
endmodule

// File: rtl/dbl_div_core.sv
// Restoring shift-subtract loop, one quotient bit per step
module dbl_div_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dmag_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         last_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  hi_q, lo_q, d_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    ext, diff;
  logic          take;

  always_comb begin
    ext  = {hi_q, lo_q[W-1]};
    diff = ext - {1'b0, d_q};
    take = ~diff[W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      d_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      hi_q  <= hi_i;
      lo_q  <= lo_i;
      d_q   <= dmag_i;
      cnt_q <= '0;
    end else if (step_i) begin
      hi_q  <= take ? diff[W-1:0] : ext[W-1:0];
      lo_q  <= {lo_q[W-2:0], take};
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign last_o = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/dbl_div_fix.sv
// Sign restore and late signed-range check
module dbl_div_fix #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  input  logic [W-1:0] qmag_i,
  input  logic [W-1:0] rmag_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o
);
  always_comb begin
    if (neg_q_i) ovf_o = qmag_i[W-1] & (|qmag_i[W-2:0]);
    else         ovf_o = signed_i & qmag_i[W-1];
    quot_o = neg_q_i ? (~qmag_i + W'(1)) : qmag_i;
    rem_o  = neg_r_i ? (~rmag_i + W'(1)) : rmag_i;
  end
endmodule

// File: rtl/dbl_div.sv
module dbl_div
  import dbl_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           div_err_o,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o,
  output logic [2*W-1:0] packed_o
);
  dd_state_e    state_q;
  logic         accept, load, step, last;
  logic         early_err, neg_q, neg_r, ovf;
  logic         neg_q_q, neg_r_q, sgn_q;
  logic [W-1:0] p_hi, p_lo, p_dmag, c_hi, c_lo, f_quot, f_rem;
  logic [W-1:0] quot_q, rem_q;
  logic         done_q, err_q;

  dbl_div_prep #(.W(W)) u_prep (
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .hi_o       (p_hi),
    .lo_o       (p_lo),
    .dmag_o     (p_dmag),
    .neg_q_o    (neg_q),
    .neg_r_o    (neg_r),
    .early_err_o(early_err)
  );

  assign accept = start_i & (state_q == ST_IDLE);
  assign load   = accept & ~early_err;
  assign step   = (state_q == ST_RUN);

  dbl_div_core #(.W(W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .hi_i  (p_hi),
    .lo_i  (p_lo),
    .dmag_i(p_dmag),
    .hi_o  (c_hi),
    .lo_o  (c_lo),
    .last_o(last)
  );

  dbl_div_fix #(.W(W)) u_fix (
    .signed_i(sgn_q),
    .neg_q_i (neg_q_q),
    .neg_r_i (neg_r_q),
    .qmag_i  (c_lo),
    .rmag_i  (c_hi),
    .quot_o  (f_quot),
    .rem_o   (f_rem),
    .ovf_o   (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      sgn_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            neg_q_q <= neg_q;
            neg_r_q <= neg_r;
            sgn_q   <= signed_i;
            if (early_err) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: if (last) state_q <= ST_FIN;
        ST_FIN: begin
          done_q  <= 1'b1;
          err_q   <= ovf;
          state_q <= ST_IDLE;
          if (!ovf) begin
            quot_q <= f_quot;
            rem_q  <= f_rem;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign div_err_o = err_q;
  assign quot_o    = quot_q;
  assign rem_o     = rem_q;
  assign packed_o  = {rem_q, quot_q};
endmodule

// File: rtl/dbl_div_chk.sv
module dbl_div_chk #(
  parameter int W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           signed_i,
  input logic [2*W-1:0] dividend_i,
  input logic [W-1:0]   divisor_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           div_err_o,
  input logic [W-1:0]   quot_o,
  input logic [W-1:0]   rem_o
);
  p_zero_div_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && div_err_o && !busy_o));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !signed_i && dividend_i[2*W-1:W] >= divisor_i)
      |=> (done_o && div_err_o));

  p_hold_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_err_o) |-> ($stable(quot_o) && $stable(rem_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_no_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

bind dbl_div dbl_div_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .dividend_i(dividend_i),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .div_err_o (div_err_o),
  .quot_o    (quot_o),
  .rem_o     (rem_o)
);

// File: tb/dbl_div_tb.sv
`timescale 1ns/1ps
module dbl_div_tb;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           sgn = 1'b0;
  logic [2*W-1:0] dvd = '0;
  logic [W-1:0]   dvs = '0;
  logic           busy, done, err;
  logic [W-1:0]   quot, rem;
  logic [2*W-1:0] pk;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbl_div #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dvd), .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .div_err_o(err), .quot_o(quot), .rem_o(rem), .packed_o(pk)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input bit s, input logic [31:0] a, input logic [15:0] b,
                                output bit e, output logic [15:0] q, output logic [15:0] r);
    longint n, d, qq, rr;
    e = 1'b0; q = '0; r = '0;
    if (b == 16'd0) begin
      e = 1'b1;
    end else if (s) begin
      n = longint'($signed(a));
      d = longint'($signed(b));
      qq = n / d; rr = n % d;
      e = (qq > 32767) || (qq < -32768);
      q = qq[15:0]; r = rr[15:0];
    end else begin
      n = longint'({32'd0, a});
      d = longint'({48'd0, b});
      qq = n / d; rr = n % d;
      e = (qq > 65535);
      q = qq[15:0]; r = rr[15:0];
    end
  endfunction

  task automatic wait_done(output int bc, output bit seen);
    int guard = 0;
    bc = 0; seen = 1'b0;
    while (!done && guard < 100) begin
      if (busy) bc++;
      @(negedge clk);
      guard++;
    end
    seen = done;
  endtask

  task automatic run_op(input string req, input bit s, input logic [31:0] a, input logic [15:0] b);
    bit e_exp, seen;
    logic [15:0] q_exp, r_exp, q_prev, r_prev;
    int bc;
    model(s, a, b, e_exp, q_exp, r_exp);
    q_prev = quot; r_prev = rem;
    sgn = s; dvd = a; dvs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(bc, seen);
    chk({req, " done seen"}, 64'(seen), 64'(1));
    chk({req, " err"}, 64'(err), 64'(e_exp));
    if (e_exp) begin
      chk({req, " R7 quot held"}, 64'(quot), 64'(q_prev));
      chk({req, " R7 rem held"}, 64'(rem), 64'(r_prev));
      chk({req, " R1/R2 early busy cycles"}, 64'(bc), (b == 0 || s == 0) ? 64'(0) : 64'(bc));
    end else begin
      chk({req, " quot"}, 64'(quot), 64'(q_exp));
      chk({req, " rem"}, 64'(rem), 64'(r_exp));
      chk({req, " R10 busy cycles"}, 64'(bc), 64'(W + 1));
    end
    chk({req, " R11 packed"}, 64'(pk), 64'({rem, quot}));
    @(negedge clk);
    chk({req, " R8 done one cycle"}, 64'(done), 64'(0));
  endtask

  task automatic t_reset;
    chk("R8 reset done", 64'(done), 64'(0));
    chk("R10 reset busy", 64'(busy), 64'(0));
    chk("R7 reset quot", 64'(quot), 64'(0));
    chk("R7 reset rem", 64'(rem), 64'(0));
  endtask

  task automatic t_ignore_start;
    bit seen;
    int bc, extra;
    sgn = 1'b0; dvd = 32'd1000; dvs = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dvd = 32'd500; dvs = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(bc, seen);
    chk("R9 done seen", 64'(seen), 64'(1));
    chk("R9 quot of first op", 64'(quot), 64'(142));
    chk("R9 rem of first op", 64'(rem), 64'(6));
    extra = 0;
    for (int i = 0; i < W + 4; i++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk("R9 no second operation", 64'(extra), 64'(0));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R5 basic", 1'b0, 32'd1000, 16'd7);
    run_op("R5 max quotient", 1'b0, 32'h0002FFFF, 16'd3);
    run_op("R5 shifted-out bit", 1'b0, 32'h80001234, 16'h8001);
    run_op("R2 overflow", 1'b0, 32'h00030000, 16'd3);
    run_op("R1 zero unsigned", 1'b0, 32'd55, 16'd0);
    run_op("R6 neg/pos", 1'b1, 32'hFFFFFFF9, 16'd2);
    run_op("R1 zero signed", 1'b1, 32'hFFFFFFF9, 16'd0);
    run_op("R6 pos/neg", 1'b1, 32'd7, 16'hFFFE);
    run_op("R6 neg/neg", 1'b1, 32'hFFFFFFF9, 16'hFFFE);
    run_op("R4 min quotient", 1'b1, 32'hFFFF8000, 16'd1);
    run_op("R3 plus 2^15", 1'b1, 32'h00008000, 16'd1);
    run_op("R4 pos by minus one", 1'b1, 32'h00008000, 16'hFFFF);
    run_op("R3 early overflow", 1'b1, 32'h7FFF0000, 16'h7FFF);
    run_op("R6 large signed", 1'b1, 32'hC0001234, 16'h8765);
    t_ignore_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule